// File: doc/BRIEF.md
# Frame Marker Synchronizer

This block recovers the frame structure of a serial bit stream whose bit timing has already been recovered upstream. Bits arrive one per cycle when `din_vld` is high. The transmitter places a short fixed marker at the start of every frame, and the frame holds a whole number of eight-bit words. The block never trusts a single pattern hit. It picks one candidate alignment at a time and compares the marker window only once per frame, at the spacing the frame length dictates. It declares lock only when enough of those per-frame comparisons agree.

When a candidate fails its trial, the position counter holds for one valid bit. This slips the candidate alignment by one bit, and a fresh trial begins. Once locked, the block keeps checking every marker. It drops back to search only after a run of consecutive misses. While locked it reports the position of each bit inside the frame, a pulse on the first payload bit after the marker, and a pulse on the last bit of every word. Downstream deframing logic uses these outputs to route words.

Top module: `fms_sync`

## Requirements
- R1: While reset is asserted, and from reset until the first lock, `lock_o`, `frame_start_o` and `word_strobe_o` are low and `bit_idx_o` is zero. The candidate alignment starts at the first valid bit after reset.
- R2: The marker (default 8'hA7, sent MSB first, occupying frame positions 0 to MARK_LEN-1) is compared once per frame, on the bit at position MARK_LEN-1. Lock is declared after that bit when at least ACCEPT (default 3) of TRIALS (default 4) consecutive checks of one candidate matched.
- R3: When a trial ends with fewer than ACCEPT matches, the position counter holds for one valid bit, so the next candidate's marker ends one bit later. With the defaults, each rejected candidate costs 97 valid bits.
- R4: A check matches when the Hamming distance between the received window and the marker is at most TOL. With the default TOL of 0, a single flipped marker bit is a miss.
- R5: While locked, fewer than MISS_LIMIT (default 2) consecutive misses keep the lock. The MISS_LIMIT-th consecutive miss drops the lock after that check bit.
- R6: After lock is dropped, search resumes at the same alignment without a slip. The next marker is the first trial check.
- R7: While locked, `frame_start_o` is high for exactly the valid bit at frame position MARK_LEN, which is the first payload bit after the marker.
- R8: While locked, `word_strobe_o` is high on each valid bit whose frame position modulo 8 equals 7.
- R9: While locked, `bit_idx_o` is the position of the current bit in its frame (0 is the first marker bit). It counts up by one per valid bit and wraps after FRAME_WORDS*8-1.
- R10: On cycles with `din_vld` low, no state advances and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | Qualifies `din` for this cycle |
| lock_o | output | 1 | Frame alignment locked |
| frame_start_o | output | 1 | First payload bit of a frame |
| word_strobe_o | output | 1 | Last bit of a word |
| bit_idx_o | output | $clog2(FRAME_WORDS*8) | Position of the current bit in the frame |

## Verification
The strobes and the bit index are combinational from registered state and the current `din_vld`. They describe the bit being presented in that same cycle. The bench samples them 5 ns after the falling edge of the cycle in which it drives the bit, before the rising edge registers the bit.

A lock change takes effect one valid bit after the deciding check bit. The scoreboard therefore marks the check bit itself with the old lock state and the next valid bit with the new one. It derives each expected lock index from the 97-bit cost of every rejected candidate.

// File: rtl/fms_pkg.sv
package fms_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } fms_state_e;

  // number of set bits in a window of up to 64 bits
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 64; i++) begin
      c = c + int'(v[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/fms_window.sv
module fms_window #(
  parameter int              MARK_LEN = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 8'hA7,
  parameter int              TOL      = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic vld_i,
  output logic match_o
);
  import fms_pkg::*;

  logic [MARK_LEN-1:0] win;
  logic [63:0]         diff;

  generate
    if (MARK_LEN == 1) begin : g_one
      assign win = bit_i;
    end else begin : g_multi
      logic [MARK_LEN-2:0] hist_q;
      assign win = {hist_q, bit_i};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
        end else if (vld_i) begin
          hist_q <= win[MARK_LEN-2:0];
        end
      end
    end
  endgenerate

  always_comb begin
    diff = '0;
    diff[MARK_LEN-1:0] = win ^ MARK_PAT;
  end

  assign match_o = (ones64(diff) <= TOL);

endmodule

// File: rtl/fms_poscnt.sv
module fms_poscnt #(
  parameter int FRAME_BITS = 32,
  parameter int MARK_LEN   = 8,
  localparam int PW        = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          hold_i,
  output logic [PW-1:0] pos_o,
  output logic          at_chk_o
);

  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv_i && !hold_i) begin
      if (pos_q == PW'(FRAME_BITS-1)) pos_d = '0;
      else                            pos_d = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o    = pos_q;
  assign at_chk_o = (pos_q == PW'(MARK_LEN-1));

endmodule

// File: rtl/fms_ctrl.sv
module fms_ctrl #(
  parameter int TRIALS     = 4,
  parameter int ACCEPT     = 3,
  parameter int MISS_LIMIT = 2,
  localparam int TW        = $clog2(TRIALS+1),
  localparam int MW        = $clog2(MISS_LIMIT+1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_i,
  input  logic match_i,
  output logic locked_o,
  output logic slip_o
);
  import fms_pkg::*;

  fms_state_e    st_q, st_d;
  logic [TW-1:0] trials_q, trials_d, hits_q, hits_d, t1, h1;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    st_d     = st_q;
    trials_d = trials_q;
    hits_d   = hits_q;
    miss_d   = miss_q;
    slip_o   = 1'b0;
    t1       = trials_q + TW'(1);
    h1       = hits_q + TW'(match_i);
    if (chk_i) begin
      case (st_q)
        ST_SEARCH: begin
          if (t1 == TW'(TRIALS)) begin
            trials_d = '0;
            hits_d   = '0;
            if (h1 >= TW'(ACCEPT)) begin
              st_d   = ST_LOCK;
              miss_d = '0;
            end else begin
              slip_o = 1'b1;
            end
          end else begin
            trials_d = t1;
            hits_d   = h1;
          end
        end
        default: begin
          if (match_i) begin
            miss_d = '0;
          end else if (miss_q + MW'(1) == MW'(MISS_LIMIT)) begin
            st_d     = ST_SEARCH;
            miss_d   = '0;
            trials_d = '0;
            hits_d   = '0;
          end else begin
            miss_d = miss_q + MW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_SEARCH;
      trials_q <= '0;
      hits_q   <= '0;
      miss_q   <= '0;
    end else begin
      st_q     <= st_d;
      trials_q <= trials_d;
      hits_q   <= hits_d;
      miss_q   <= miss_d;
    end
  end

  assign locked_o = (st_q == ST_LOCK);

endmodule

// File: rtl/fms_sync.sv
module fms_sync #(
  parameter int                  WORD_BITS   = 8,
  parameter int                  FRAME_WORDS = 4,
  parameter int                  MARK_LEN    = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT    = 8'hA7,
  parameter int                  TRIALS      = 4,
  parameter int                  ACCEPT      = 3,
  parameter int                  MISS_LIMIT  = 2,
  parameter int                  TOL         = 0,
  localparam int                 FRAME_BITS  = WORD_BITS*FRAME_WORDS,
  localparam int                 PW          = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          din_vld,
  output logic          lock_o,
  output logic          frame_start_o,
  output logic          word_strobe_o,
  output logic [PW-1:0] bit_idx_o
);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          match, at_chk, chk, slip, locked;
  logic [PW-1:0] pos;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  fms_window #(
    .MARK_LEN (MARK_LEN),
    .MARK_PAT (MARK_PAT),
    .TOL      (TOL)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_i   (din),
    .vld_i   (din_vld),
    .match_o (match)
  );

  fms_poscnt #(
    .FRAME_BITS (FRAME_BITS),
    .MARK_LEN   (MARK_LEN)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv_i    (din_vld),
    .hold_i   (slip),
    .pos_o    (pos),
    .at_chk_o (at_chk)
  );

  assign chk = din_vld & at_chk;

  fms_ctrl #(
    .TRIALS     (TRIALS),
    .ACCEPT     (ACCEPT),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chk_i    (chk),
    .match_i  (match),
    .locked_o (locked),
    .slip_o   (slip)
  );

  assign lock_o        = locked;
  assign frame_start_o = locked & din_vld & (pos == PW'(MARK_LEN));
  assign word_strobe_o = locked & din_vld &
                         ((pos % PW'(WORD_BITS)) == PW'(WORD_BITS-1));
  assign bit_idx_o     = locked ? pos : '0;

endmodule

// File: rtl/fms_sync_chk.sv
module fms_sync_chk #(
  parameter int MARK_LEN   = 8,
  parameter int FRAME_BITS = 32,
  parameter int PW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          din_vld,
  input logic          lock,
  input logic          frame_start,
  input logic          word_strobe,
  input logic [PW-1:0] bit_idx
);

  p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (!frame_start && !word_strobe && bit_idx == '0));

  p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (bit_idx == PW'(MARK_LEN)));

  p_fs_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (din_vld && bit_idx == PW'(MARK_LEN)));

  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && din_vld && bit_idx != PW'(FRAME_BITS-1)) |=>
      (!lock || bit_idx == $past(bit_idx) + PW'(1)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(lock) && $stable(bit_idx)));

endmodule

bind fms_sync fms_sync_chk #(
  .MARK_LEN   (MARK_LEN),
  .FRAME_BITS (FRAME_BITS),
  .PW         (PW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .din_vld     (din_vld),
  .lock        (lock_o),
  .frame_start (frame_start_o),
  .word_strobe (word_strobe_o),
  .bit_idx     (bit_idx_o)
);

// File: tb/sim_fms_sync.sv
module sim_fms_sync;
  localparam int         FB   = 32;
  localparam int         ML   = 8;
  localparam logic [7:0] MK   = 8'hA7;
  localparam int         NONE = 1 << 30;

  logic       clk = 1'b0;
  logic       rst_n, din, din_vld;
  logic       lock, fs, ws;
  logic [4:0] idx;

  always #10 clk = ~clk;

  fms_sync u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .din           (din),
    .din_vld       (din_vld),
    .lock_o        (lock),
    .frame_start_o (fs),
    .word_strobe_o (ws),
    .bit_idx_o     (idx)
  );

  typedef struct packed {
    int         n;
    logic       lk;
    logic       fs;
    logic       ws;
    logic [4:0] idx;
  } exp_t;

  exp_t  sbq[$];
  exp_t  cur;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    mon_en = 1'b0;
  string tag    = "";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per valid bit
  always @(negedge clk) begin
    #5;
    if (mon_en) begin
      if (din_vld) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R10 scoreboard empty", 0, 1);
        end else begin
          cur = sbq.pop_front();
          check(lock == cur.lk, $sformatf("%s lock at bit %0d", tag, cur.n), int'(lock), int'(cur.lk));
          check(idx == cur.idx, $sformatf("R9 bit_idx at bit %0d", cur.n), int'(idx), int'(cur.idx));
          check(fs == cur.fs, $sformatf("R7 frame_start at bit %0d", cur.n), int'(fs), int'(cur.fs));
          check(ws == cur.ws, $sformatf("R8 word_strobe at bit %0d", cur.n), int'(ws), int'(cur.ws));
        end
      end else begin
        check(!fs && !ws, "R10 strobes on idle cycle", int'({fs, ws}), 0);
      end
    end
  end

  task automatic do_reset();
    mon_en  = 1'b0;
    rst_n   = 1'b0;
    din_vld = 1'b0;
    din     = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    check(!lock, "R1 lock in reset", int'(lock), 0);
    check(!fs, "R1 frame_start in reset", int'(fs), 0);
    check(!ws, "R1 word_strobe in reset", int'(ws), 0);
    check(idx == 5'd0, "R1 bit_idx in reset", int'(idx), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
  endtask

  // d: marker offset, nf: frames, badm: frames with a flipped marker bit,
  // lk_on/lk_off/lk_re: check-bit indices of lock, drop and relock
  task automatic send(input int d, input int nf, input logic [127:0] badm,
                      input int lk_on, input int lk_off, input int lk_re);
    for (int n = 0; n < d + FB*nf; n++) begin
      int   rel, p, f;
      logic b;
      exp_t e;
      if (n % 5 == 4) begin
        @(negedge clk);
        din_vld = 1'b0;
        din     = 1'b0;
      end
      rel = n - d;
      if (rel < 0) begin
        b = 1'b0;
      end else begin
        p = rel % FB;
        f = rel / FB;
        if (p < ML) begin
          b = MK[ML-1-p];
          if (badm[f] && p == 0) b = ~b;
        end else begin
          b = logic'((f + p/8) % 2);
        end
      end
      @(negedge clk);
      din     = b;
      din_vld = 1'b1;
      e.n   = n;
      e.lk  = ((n > lk_on) && (n <= lk_off)) || (n > lk_re);
      e.idx = e.lk ? 5'(rel % FB) : 5'd0;
      e.fs  = e.lk && (e.idx == 5'(ML));
      e.ws  = e.lk && (e.idx % 8 == 5'd7);
      sbq.push_back(e);
    end
    @(negedge clk);
    din_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [127:0] m;
    do_reset();
    // R3 five rejected candidates, R5 single miss held, R6 relock after drop
    tag = "R3 R5 R6";
    m = '0; m[21] = 1'b1; m[24] = 1'b1; m[25] = 1'b1;
    send(5, 33, m, 588, 812, 940);
    do_reset();
    // R2 three of four matches locks, R4 flipped bit is a miss
    tag = "R2 R4";
    m = '0; m[2] = 1'b1;
    send(0, 7, m, 103, NONE, NONE);
    do_reset();
    // R3 two of four rejects, full wrap of 32 candidates, R4
    tag = "R3 R4";
    m = '0; m[1] = 1'b1; m[2] = 1'b1;
    send(0, 103, m, 3207, NONE, NONE);
    check(sbq.size() == 0, "R10 scoreboard drained", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule